// File: doc/BRIEF.md
# Dual-Technique Autoranging Input Controller

This block chooses which of two measurement paths feeds one current-measurement channel. A pulse-counting current-to-frequency path covers the low end of the current range. A direct ADC path covers the high end. The two paths overlap over a wide band of currents. The block drives the front-end path select. All range decisions are made in digital logic, and the front end never changes its gain.

On every input sample strobe the controller takes the per-sample pulse count and the ADC code. It reports one measurement in common units. In counting mode the count is passed through unchanged. In ADC mode the ADC code is multiplied by a fixed scale constant. Each result carries a range tag and a good flag. The controller moves up to ADC mode when the pulse count reaches a programmable limit. It moves back down when the ADC code drops below a programmable low level. Setting that level well inside the overlap band gives hysteresis, so the channel does not chatter between paths. The first sample taken after a path change is marked not good, and it cannot start another change.

Top module: `autorange_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `range_sel` is 0 (counting mode) and `meas_valid` is 0.
- R2: On a sample in counting mode that is not a settling sample, if `cnt_in >= cnt_limit`, then `range_sel` becomes 1 (ADC mode) at the clock edge that accepts the sample.
- R3: On a sample in ADC mode that is not a settling sample, if `adc_in < adc_low`, then `range_sel` becomes 0 at the clock edge that accepts the sample. A code equal to `adc_low` keeps ADC mode.
- R4: In counting mode the ADC code has no effect on the range. In ADC mode the pulse count has no effect on the range.
- R5: The first sample accepted after a range change reports `meas_good` = 0. All other samples report `meas_good` = 1.
- R6: A settling sample never changes `range_sel`, whatever its count or code.
- R7: A counting-mode sample reports `meas_range` = 0 and `meas_value` = `cnt_in` zero-extended.
- R8: An ADC-mode sample reports `meas_range` = 1 and `meas_value` = `adc_in * ADC_SCALE`. The default `ADC_SCALE` is 12.
- R9: `meas_valid` is high for exactly the one cycle after each cycle where `smp_valid` is high. Without a sample, `range_sel` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe; count and code are valid |
| cnt_in | input | CNT_W | Pulse count for this sample |
| adc_in | input | ADC_W | ADC code for this sample |
| cnt_limit | input | CNT_W | Count level that triggers the move to ADC mode |
| adc_low | input | ADC_W | ADC level below which the channel returns to counting mode |
| range_sel | output | 1 | Front-end path select: 0 counting, 1 ADC |
| meas_valid | output | 1 | Measurement output strobe |
| meas_value | output | OUT_W | Measurement in common units |
| meas_range | output | 1 | Path that produced the measurement |
| meas_good | output | 1 | 0 for the settling sample after a range change |

## Verification
The bench drives the count exactly at the limit and one below it, and the ADC code exactly at the low level and one below it. A design with an off-by-one comparison would switch one sample early or late, and the range tag and scaled value of the following samples would show it. It puts saturated counts in ADC mode and tiny ADC codes in counting mode. A design that mixed up the two decision inputs would bounce between paths. It also presents switch-worthy data on the settling sample itself. A design that skipped the settling inhibit would switch again at once and report that sample as good.

// File: rtl/autorange_pkg.sv
package autorange_pkg;
  typedef enum logic {
    RNG_CNT = 1'b0,
    RNG_ADC = 1'b1
  } range_e;
endpackage

// File: rtl/ar_mode_ctrl.sv
module ar_mode_ctrl
  import autorange_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int ADC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic [ADC_W-1:0] adc_in,
  input  logic [CNT_W-1:0] cnt_limit,
  input  logic [ADC_W-1:0] adc_low,
  output range_e           mode_q,
  output logic             settle_q
);
  range_e mode_d;
  logic   settle_d;
  logic   go_up, go_down;

  // decision inputs are selected by the current mode only
  assign go_up   = (mode_q == RNG_CNT) && (cnt_in >= cnt_limit);
  assign go_down = (mode_q == RNG_ADC) && (adc_in < adc_low);

  always_comb begin
    mode_d   = mode_q;
    settle_d = settle_q;
    if (smp_valid) begin
      if (settle_q) begin
        settle_d = 1'b0;
      end else if (go_up) begin
        mode_d   = RNG_ADC;
        settle_d = 1'b1;
      end else if (go_down) begin
        mode_d   = RNG_CNT;
        settle_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= RNG_CNT;
      settle_q <= 1'b0;
    end else if (smp_valid) begin
      mode_q   <= mode_d;
      settle_q <= settle_d;
    end
  end

  p_up_on_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !settle_q && mode_q == RNG_CNT && cnt_in >= cnt_limit |=> mode_q == RNG_ADC);

  p_down_below_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !settle_q && mode_q == RNG_ADC && adc_in < adc_low |=> mode_q == RNG_CNT);

  p_settle_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && settle_q |=> $stable(mode_q) && !settle_q);

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(mode_q));

  p_change_marks_settle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> settle_q);
endmodule

// File: rtl/ar_value_fmt.sv
module ar_value_fmt
  import autorange_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int ADC_W     = 16,
  parameter int ADC_SCALE = 12,
  parameter int OUT_W     = 20
) (
  input  range_e           mode,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic [ADC_W-1:0] adc_in,
  output logic [OUT_W-1:0] value
);
  localparam int SCALE_W = $clog2(ADC_SCALE + 1);
  localparam int PROD_W  = ADC_W + SCALE_W;

  logic [PROD_W-1:0] adc_scaled;

  assign adc_scaled = PROD_W'(adc_in) * PROD_W'(ADC_SCALE);

  always_comb begin
    if (mode == RNG_ADC) value = OUT_W'(adc_scaled);
    else                 value = OUT_W'(cnt_in);
  end
endmodule

// File: rtl/ar_out_reg.sv
module ar_out_reg
  import autorange_pkg::*;
#(
  parameter int OUT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [OUT_W-1:0] value_in,
  input  range_e           range_in,
  input  logic             good_in,
  output logic             meas_valid,
  output logic [OUT_W-1:0] meas_value,
  output logic             meas_range,
  output logic             meas_good
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) meas_valid <= 1'b0;
    else        meas_valid <= smp_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas_value <= '0;
      meas_range <= 1'b0;
      meas_good  <= 1'b0;
    end else if (smp_valid) begin
      meas_value <= value_in;
      meas_range <= range_in;
      meas_good  <= good_in;
    end
  end

  p_strobe_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> meas_valid);

  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !meas_valid);
endmodule

// File: rtl/autorange_ctrl.sv
module autorange_ctrl
  import autorange_pkg::*;
#(
  parameter int  CNT_W     = 16,
  parameter int  ADC_W     = 16,
  parameter int  ADC_SCALE = 12,
  localparam int SCALE_W   = $clog2(ADC_SCALE + 1),
  localparam int PROD_W    = ADC_W + SCALE_W,
  localparam int OUT_W     = (PROD_W > CNT_W) ? PROD_W : CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic [ADC_W-1:0] adc_in,
  input  logic [CNT_W-1:0] cnt_limit,
  input  logic [ADC_W-1:0] adc_low,
  output logic             range_sel,
  output logic             meas_valid,
  output logic [OUT_W-1:0] meas_value,
  output logic             meas_range,
  output logic             meas_good
);
  range_e           mode_q;
  logic             settle_q;
  logic [OUT_W-1:0] value_c;

  ar_mode_ctrl #(.CNT_W(CNT_W), .ADC_W(ADC_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .cnt_in(cnt_in), .adc_in(adc_in),
    .cnt_limit(cnt_limit), .adc_low(adc_low),
    .mode_q(mode_q), .settle_q(settle_q)
  );

  ar_value_fmt #(.CNT_W(CNT_W), .ADC_W(ADC_W), .ADC_SCALE(ADC_SCALE), .OUT_W(OUT_W)) u_fmt (
    .mode(mode_q), .cnt_in(cnt_in), .adc_in(adc_in), .value(value_c)
  );

  ar_out_reg #(.OUT_W(OUT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .value_in(value_c), .range_in(mode_q), .good_in(!settle_q),
    .meas_valid(meas_valid), .meas_value(meas_value),
    .meas_range(meas_range), .meas_good(meas_good)
  );

  assign range_sel = mode_q;

  p_tag_matches_path_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> meas_range == $past(range_sel));

  p_settling_not_good_r5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !$stable(range_sel) |=> !meas_good);
endmodule

// File: tb/autorange_ctrl_bench.sv
module autorange_ctrl_bench;
  localparam int CNT_W = 16, ADC_W = 16, SCALE = 12;
  localparam int OUT_W = ADC_W + $clog2(SCALE + 1);

  logic clk = 1'b0, rst_n = 1'b0, smp_valid = 1'b0;
  logic [CNT_W-1:0] cnt_in = '0, cnt_limit = 16'd60000;
  logic [ADC_W-1:0] adc_in = '0, adc_low = 16'd500;
  logic range_sel, meas_valid, meas_range, meas_good;
  logic [OUT_W-1:0] meas_value;

  typedef struct {
    logic [OUT_W-1:0] val;
    logic rng, good, nxt;
  } item_t;
  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  logic m_mode = 1'b0, m_settle = 1'b0;

  always #5 clk = ~clk;

  autorange_ctrl u_autorange_ctrl (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .cnt_in(cnt_in), .adc_in(adc_in), .cnt_limit(cnt_limit), .adc_low(adc_low),
    .range_sel(range_sel), .meas_valid(meas_valid), .meas_value(meas_value),
    .meas_range(meas_range), .meas_good(meas_good)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: model the requirements, push expected item, drive one sample
  task automatic send(input int c, input int a);
    item_t it;
    it.rng  = m_mode;
    it.good = !m_settle;
    it.val  = m_mode ? OUT_W'(a * SCALE) : OUT_W'(c);
    if (m_settle) m_settle = 1'b0;
    else if (!m_mode && c >= int'(cnt_limit)) begin m_mode = 1'b1; m_settle = 1'b1; end
    else if (m_mode && a < int'(adc_low))     begin m_mode = 1'b0; m_settle = 1'b1; end
    it.nxt = m_mode;
    @(negedge clk);
    cnt_in = CNT_W'(c); adc_in = ADC_W'(a); smp_valid = 1'b1;
    q.push_back(it);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      chk(range_sel == m_mode, "R9 range holds when idle", range_sel, m_mode);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && meas_valid) begin
      if (q.size() == 0) chk(1'b0, "R9 unexpected meas_valid", 1, 0);
      else begin
        item_t e;
        e = q.pop_front();
        chk(meas_value == e.val, e.rng ? "R8 value" : "R7 value", meas_value, e.val);
        chk(meas_range == e.rng, "R7/R8 range tag", meas_range, e.rng);
        chk(meas_good == e.good, "R5 good flag", meas_good, e.good);
        chk(range_sel == e.nxt, "R2/R3/R4/R6 range_sel", range_sel, e.nxt);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(range_sel == 1'b0, "R1 reset range", range_sel, 0);
    chk(meas_valid == 1'b0, "R1 reset valid", meas_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(range_sel == 1'b0, "R1 after release", range_sel, 0);
    send(100, 0); send(0, 7); send(2000, 9);
    send(10, 0);              // R4 tiny ADC code ignored in counting mode
    send(59999, 0);           // R2 one below limit: stays
    idle(3);
    send(60000, 0);           // R2 at limit: up
    send(0, 3);               // R6 settling sample, low code ignored; R5 not good
    send(0, 500);             // R3 equal to low: stays
    send(65535, 900);         // R4 saturated count ignored in ADC mode
    idle(2);
    send(0, 499);             // R3 below low: down
    send(65535, 0);           // R6 settling, saturated count ignored
    send(1234, 0);
    send(65535, 0);           // R2 up again
    send(5, 65535);           // R8 full-scale code, settling
    send(5, 4000);
    idle(2);
    @(negedge clk); @(negedge clk);
    chk(q.size() == 0, "R9 all results seen", q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule